// File: doc/BRIEF.md
# Iterative Leading-One Normalizer

This unit takes a 32-bit operand and shifts it left one position per clock until its most significant bit is 1. It returns the normalized value, an 8-bit count of the positions shifted and a zero flag. An operand of all zeroes skips the shift loop. It returns zero with a count of 0 and sets the flag.

A one-cycle `start` pulse, sampled while the unit is idle, captures `operand_i` and begins an operation. `busy` is high in every cycle of the operation. `done` is high only in the last of those cycles, and `busy` falls in the next cycle. The number of busy cycles depends on the data. A non-zero operand takes a fixed overhead of 6 cycles plus one cycle per shift position. An all-zero operand takes exactly 4 cycles. The results are valid from the `done` cycle. They hold their values until the next accepted start.

Top module: `lz_normalizer`

## Requirements
- R1: While reset is asserted and after it is released with no start, `busy`, `done`, `result_o`, `shift_count_o` and `zero_flag_o` are all 0.
- R2: A `start` high at a clock edge while `busy` is low begins an operation. `busy` is high from the next cycle through the last cycle of the operation. `done` is high in exactly one cycle, which is the last busy cycle, and `busy` is low in the cycle after it.
- R3: For a non-zero operand, `result_o` at `done` has bit 31 set and equals the operand shifted left by `shift_count_o`, with zeroes entering at bit 0.
- R4: For a non-zero operand, `shift_count_o` at `done` equals the number of zero bits above the highest 1 bit of the operand, in the range 0 to 31.
- R5: For a non-zero operand, the operation lasts exactly 6 + `shift_count_o` busy cycles, so the longest case is 37 cycles.
- R6: For an all-zero operand, the operation lasts exactly 4 busy cycles, and at `done` the outputs are `result_o` = 0, `shift_count_o` = 0 and `zero_flag_o` = 1.
- R7: An operand with bit 31 already set finishes in 6 cycles with a count of 0 and the value unchanged.
- R8: For a non-zero operand, `zero_flag_o` is 0 at `done`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its operand, its result and its latency.
- R10: While `busy` is low and no start is sampled, `result_o`, `shift_count_o` and `zero_flag_o` keep their values, whatever `operand_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin normalizing `operand_i` |
| operand_i | input | 32 | Value to normalize, captured when a start is accepted |
| busy | output | 1 | High during every cycle of an operation |
| done | output | 1 | High in the final cycle of an operation |
| result_o | output | 32 | Normalized value |
| shift_count_o | output | 8 | Number of left shifts applied |
| zero_flag_o | output | 1 | Set when the operand was all zeroes |

## Verification
Several rules are checked by assertions on every cycle. Every cycle's shift sees a 0 in the top bit and a count below 31. The busy-cycle count at `done` matches the cycle formula for the count and flag it reports. `done` is followed by idle, a normalized result has its top bit set, and a zero result carries a zero count. Idle outputs hold their values, and a start during an operation does not restart the cycle count. Some facts the assertions cannot see, because the unit does not keep the original operand. One is that the count equals the true leading-zero count. Another is that the result is the operand shifted by exactly that amount. A third is that a second start leaves the first operation's value untouched. The bench's directed scenarios show these by comparing against a model computed from the operand.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  typedef enum logic [1:0] {
    NRM_IDLE  = 2'd0,
    NRM_LEAD  = 2'd1,
    NRM_SHIFT = 2'd2,
    NRM_TAIL  = 2'd3
  } nrm_state_e;

  // Busy-cycle length of one operation, given its outcome.
  function automatic int unsigned nrm_cycles(input bit was_zero,
                                             input int unsigned shifts,
                                             input int unsigned lead,
                                             input int unsigned tail,
                                             input int unsigned zero_tail);
    if (was_zero) return lead + zero_tail;
    return lead + shifts + tail;
  endfunction

  function automatic int unsigned nrm_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nrm_shifter.sv
module nrm_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              shift_en_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] value_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              zero_flag_o,
  output logic              src_zero_o,
  output logic              src_msb_o,
  output logic              next_msb_o
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] shl1(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  logic [DATA_W-1:0] value_q;
  logic [CNT_W-1:0]  count_q;
  logic              zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      count_q <= '0;
      zero_q  <= 1'b0;
    end else begin
      if (load_en_i) begin
        value_q <= operand_i;
        count_q <= '0;
      end else if (shift_en_i) begin
        value_q <= shl1(value_q);
        count_q <= count_q + 1'b1;
      end
      if (flag_en_i) zero_q <= src_zero_o;
    end
  end

  assign src_zero_o  = (value_q == '0);
  assign src_msb_o   = value_q[MSB];
  assign next_msb_o  = value_q[MSB-1];
  assign value_o     = value_q;
  assign count_o     = count_q;
  assign zero_flag_o = zero_q;

  // R4
  shift_zero_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |-> !value_q[MSB]);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |-> (count_q < CNT_W'(DATA_W - 1)));

endmodule

// File: rtl/nrm_sequencer.sv
module nrm_sequencer
  import nrm_pkg::*;
#(
  parameter int LEAD_CYCLES      = 2,
  parameter int TAIL_CYCLES      = 4,
  parameter int ZERO_TAIL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic src_zero_i,
  input  logic src_msb_i,
  input  logic next_msb_i,
  output logic load_en_o,
  output logic shift_en_o,
  output logic lead_end_o,
  output logic busy_o,
  output logic done_o
);

  localparam int PH_MAX = int'(nrm_max3(LEAD_CYCLES, TAIL_CYCLES, ZERO_TAIL_CYCLES));
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam logic [PH_W-1:0] LEAD_LD  = PH_W'(LEAD_CYCLES - 1);
  localparam logic [PH_W-1:0] TAIL_LD  = PH_W'(TAIL_CYCLES - 1);
  localparam logic [PH_W-1:0] ZTAIL_LD = PH_W'(ZERO_TAIL_CYCLES - 1);

  nrm_state_e      state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            tail_end;

  assign load_en_o  = (state_q == NRM_IDLE) && start_i;
  assign lead_end_o = (state_q == NRM_LEAD) && (phase_q == '0);
  assign tail_end   = (state_q == NRM_TAIL) && (phase_q == '0);
  assign shift_en_o = (state_q == NRM_SHIFT);
  assign busy_o     = (state_q != NRM_IDLE);
  assign done_o     = tail_end;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    unique case (state_q)
      NRM_IDLE: begin
        if (start_i) begin
          state_d = NRM_LEAD;
          phase_d = LEAD_LD;
        end
      end
      NRM_LEAD: begin
        if (phase_q != '0) begin
          phase_d = phase_q - 1'b1;
        end else if (src_zero_i) begin
          state_d = NRM_TAIL;
          phase_d = ZTAIL_LD;
        end else if (src_msb_i) begin
          state_d = NRM_TAIL;
          phase_d = TAIL_LD;
        end else begin
          state_d = NRM_SHIFT;
        end
      end
      NRM_SHIFT: begin
        if (next_msb_i) begin
          state_d = NRM_TAIL;
          phase_d = TAIL_LD;
        end
      end
      NRM_TAIL: begin
        if (phase_q != '0) phase_d = phase_q - 1'b1;
        else               state_d = NRM_IDLE;
      end
      default: state_d = NRM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NRM_IDLE;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R2
  done_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !done_o));

endmodule

// File: rtl/lz_normalizer.sv
module lz_normalizer
  import nrm_pkg::*;
#(
  parameter int DATA_W           = 32,
  parameter int CNT_W            = 8,
  parameter int LEAD_CYCLES      = 2,
  parameter int TAIL_CYCLES      = 4,
  parameter int ZERO_TAIL_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result_o,
  output logic [CNT_W-1:0]  shift_count_o,
  output logic              zero_flag_o
);

  localparam int MAX_LAT = LEAD_CYCLES + TAIL_CYCLES + DATA_W;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  // Named internal events between datapath and sequencer.
  logic load_en, shift_en, lead_end;
  logic src_zero, src_msb, next_msb;

  nrm_sequencer #(
    .LEAD_CYCLES      (LEAD_CYCLES),
    .TAIL_CYCLES      (TAIL_CYCLES),
    .ZERO_TAIL_CYCLES (ZERO_TAIL_CYCLES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .src_zero_i (src_zero),
    .src_msb_i  (src_msb),
    .next_msb_i (next_msb),
    .load_en_o  (load_en),
    .shift_en_o (shift_en),
    .lead_end_o (lead_end),
    .busy_o     (busy),
    .done_o     (done)
  );

  nrm_shifter #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en_i   (load_en),
    .operand_i   (operand_i),
    .shift_en_i  (shift_en),
    .flag_en_i   (lead_end),
    .value_o     (result_o),
    .count_o     (shift_count_o),
    .zero_flag_o (zero_flag_o),
    .src_zero_o  (src_zero),
    .src_msb_o   (src_msb),
    .next_msb_o  (next_msb)
  );

  // Busy-cycle index of the running operation, for the latency property.
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (load_en) lat_q <= LAT_W'(1);
    else if (busy)    lat_q <= lat_q + 1'b1;
  end

  // R5 R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT_W'(nrm_cycles(zero_flag_o, 32'(shift_count_o),
                                         LEAD_CYCLES, TAIL_CYCLES, ZERO_TAIL_CYCLES))));

  // R3
  normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !zero_flag_o) |-> result_o[DATA_W-1]);

  // R6
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_flag_o) |-> (result_o == '0 && shift_count_o == '0));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result_o[DATA_W-1]) |-> !zero_flag_o);

  // R9
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy && lat_q == $past(lat_q) + 1'b1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result_o) && $stable(shift_count_o) && $stable(zero_flag_o)));

endmodule

// File: tb/lz_normalizer_test.sv
module lz_normalizer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand_i = '0;
  logic        busy, done, zero_flag_o;
  logic [31:0] result_o;
  logic [7:0]  shift_count_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  lz_normalizer uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .operand_i     (operand_i),
    .busy          (busy),
    .done          (done),
    .result_o      (result_o),
    .shift_count_o (shift_count_o),
    .zero_flag_o   (zero_flag_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Independent reference: walk the bits from the top.
  task automatic model(input logic [31:0] op, output logic [31:0] norm,
                       output int n, output int lat);
    norm = op;
    n = 0;
    if (op == 0) begin
      lat = 4;
    end else begin
      while (norm[31] == 1'b0) begin
        norm = norm << 1;
        n++;
      end
      lat = 6 + n;
    end
  endtask

  // One operation; an optional second start at busy cycle mid_at (0 = none).
  task automatic run_case(input logic [31:0] op, input int mid_at, input string name);
    logic [31:0] exp_v;
    int exp_n, exp_lat, cyc, done_at, dones;
    model(op, exp_v, exp_n, exp_lat);
    @(negedge clk);
    operand_i = op;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; done_at = 0; dones = 0;
    while (busy && cyc < 64) begin
      cyc++;
      if (done) begin dones++; done_at = cyc; end
      if (mid_at != 0 && cyc == mid_at) begin
        start = 1'b1;
        operand_i = ~op;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    // R2 busy length and single done in last busy cycle
    check(cyc == exp_lat, {"R2/R5/R6 busy cycles ", name}, cyc, exp_lat);
    check(done_at == exp_lat && dones == 1, {"R2 done position ", name}, done_at, exp_lat);
    // R3 normalized value
    check(result_o == exp_v, {"R3 result ", name}, result_o, exp_v);
    // R4 shift count
    check(shift_count_o == 8'(exp_n), {"R4 count ", name}, shift_count_o, exp_n);
    // R8 / R6 zero flag
    check(zero_flag_o == (op == 0), {"R8/R6 zero flag ", name}, zero_flag_o, (op == 0));
  endtask

  task automatic reset_case();
    @(negedge clk);
    // R1 during reset
    check(!busy && !done && result_o == 0 && shift_count_o == 0 && !zero_flag_o,
          "R1 outputs in reset", {busy, done, zero_flag_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release, no start
    check(!busy && !done && result_o == 0 && shift_count_o == 0 && !zero_flag_o,
          "R1 outputs after reset", result_o, 0);
  endtask

  task automatic idle_hold_case();
    logic [31:0] v;
    logic [7:0]  c;
    logic        z;
    v = result_o; c = shift_count_o; z = zero_flag_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      operand_i = 32'hA5A5_0000 ^ 32'(i);
    end
    @(negedge clk);
    // R10 outputs hold while idle
    check(result_o == v && shift_count_o == c && zero_flag_o == z && !busy,
          "R10 idle hold", result_o, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_case();
    run_case(32'h0000_0000, 0, "zero");          // R6
    run_case(32'h8000_0000, 0, "msb set");       // R7
    run_case(32'hFFFF_FFFF, 0, "all ones");      // R7
    run_case(32'h0000_0001, 0, "lsb only");      // R5 worst case 37
    run_case(32'h0001_0000, 0, "mid bit");
    run_case(32'h1234_5678, 0, "mixed");
    run_case(32'h4000_0000, 0, "one shift");
    run_case(32'h0000_0003, 0, "low pair");
    idle_hold_case();
    run_case(32'h0000_0100, 4, "restart mid");   // R9
    run_case(32'h0000_0000, 2, "restart zero");  // R9
    run_case(32'h0000_0001, 20, "restart late"); // R9
    idle_hold_case();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule